// File: doc/BRIEF.md
# Addressed Single-Bit Discrete Port

This block holds a bank of single-bit output latches, one per bidirectional terminal, and lets the processor reach exactly one terminal at a time through a 4-bit index. The index comes from an external index register. A write command drives the selected latch high or low. A sense command reads the selected terminal and returns one bit to the branch logic.

Each terminal is open-drain. While its latch holds 0, the latch pulls the pin low. The level the block reads is therefore the wired AND of the latch and the level applied from outside. Software must leave a latch at 1 before it can observe an external signal on that terminal. After reset every latch holds 1, so every terminal starts as an input.

The sensed bit is registered. It appears for exactly one cycle after the sense command, together with a valid strobe. The pad cells and the index register are not part of this block.

Top module: `dio_bit_port`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `pin_out` becomes 1 and both `sense_valid` and `sense_bit` become 0.
- R2: When `set_en` is 1 and `clr_en` is 0 at an edge, `pin_out[sel]` becomes 1 after that edge. Every other bit of `pin_out` keeps its value.
- R3: When `clr_en` is 1 at an edge, `pin_out[sel]` becomes 0 after that edge. Every other bit of `pin_out` keeps its value.
- R4: When `set_en` and `clr_en` are both 1 in the same cycle, the clear takes effect and the addressed bit becomes 0.
- R5: When `sense_en` is 1 at an edge, `sense_valid` is 1 for the following cycle. `sense_bit` in that cycle equals `pin_out[sel] & pin_in[sel]` as sampled at that edge.
- R6: In any cycle after an edge where `sense_en` was 0, `sense_valid` and `sense_bit` are both 0.
- R7: When neither `set_en` nor `clr_en` is 1, `pin_out` does not change, whatever the values of `sense_en`, `sel` or `pin_in`.
- R8: When a sense and a write to the same terminal occur in the same cycle, the sensed value uses the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 4 | Index of the addressed terminal |
| set_en | input | 1 | Drive the addressed latch to 1 |
| clr_en | input | 1 | Drive the addressed latch to 0 (wins over set) |
| sense_en | input | 1 | Sample the addressed terminal |
| pin_in | input | 16 | Level applied to each terminal from outside |
| pin_out | output | 16 | Latch state; 0 pulls the terminal low |
| sense_valid | output | 1 | One-cycle strobe after a sense command |
| sense_bit | output | 1 | Sensed terminal level, valid with the strobe |

## Verification
Writes go to random indices under random external levels. This shows that only the addressed bit moves, and that clear beats set when both are requested. Senses are issued against all four combinations of latch and external level, so the wired AND is separated from a plain read of either source alone. Senses that land in the same cycle as a write to the same index show whether the old or the new latch value is read. Long idle stretches with a changing `pin_in` and a changing index show that the latches stay put and that the strobe stays low.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int unsigned DEF_TERMS = 16;

    typedef enum logic [1:0] {
        WR_HOLD = 2'd0,
        WR_SET  = 2'd1,
        WR_CLR  = 2'd2
    } wr_op_e;

    typedef struct packed {
        logic valid;
        logic level;
    } sense_t;

    // Clear has priority over set.
    function automatic wr_op_e resolve_op(input logic set_req, input logic clr_req);
        if (clr_req) return WR_CLR;
        if (set_req) return WR_SET;
        return WR_HOLD;
    endfunction

endpackage

// File: rtl/dio_index_dec.sv
module dio_index_dec #(
    parameter int unsigned N_TERM = 16,
    localparam int unsigned IDX_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [N_TERM-1:0] hot
);
    for (genvar g = 0; g < N_TERM; g++) begin : g_dec
        assign hot[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/dio_latch_cell.sv
module dio_latch_cell
    import dio_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   picked,
    input  wr_op_e op,
    output logic   q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b1;
        end else if (picked) begin
            case (op)
                WR_SET:  q <= 1'b1;
                WR_CLR:  q <= 1'b0;
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/dio_sense_path.sv
module dio_sense_path
    import dio_pkg::*;
#(
    parameter int unsigned N_TERM = 16,
    localparam int unsigned IDX_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [N_TERM-1:0] hot,
    input  logic [N_TERM-1:0] latch_q,
    input  logic [N_TERM-1:0] ext_lvl,
    output sense_t            res
);
    logic [N_TERM-1:0] wired;
    logic              picked_lvl;

    // Open-drain: the terminal reads low if either side pulls it low.
    assign wired      = latch_q & ext_lvl;
    assign picked_lvl = |(wired & hot);

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid <= req;
            res.level <= req & picked_lvl;
        end
    end
endmodule

// File: rtl/dio_bit_port.sv
module dio_bit_port
    import dio_pkg::*;
#(
    parameter int unsigned N_TERM = DEF_TERMS,
    localparam int unsigned IDX_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  sel,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic              sense_en,
    input  logic [N_TERM-1:0] pin_in,
    output logic [N_TERM-1:0] pin_out,
    output logic              sense_valid,
    output logic              sense_bit
);
    logic [N_TERM-1:0] hot;
    wr_op_e            op;
    sense_t            res;

    assign op = resolve_op(set_en, clr_en);

    dio_index_dec #(.N_TERM(N_TERM)) u_dec (
        .idx (sel),
        .hot (hot)
    );

    for (genvar g = 0; g < N_TERM; g++) begin : g_cell
        dio_latch_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .picked (hot[g]),
            .op     (op),
            .q      (pin_out[g])
        );
    end

    dio_sense_path #(.N_TERM(N_TERM)) u_sense (
        .clk     (clk),
        .rst     (rst),
        .req     (sense_en),
        .hot     (hot),
        .latch_q (pin_out),
        .ext_lvl (pin_in),
        .res     (res)
    );

    assign sense_valid = res.valid;
    assign sense_bit   = res.level;
endmodule

// File: rtl/dio_bit_port_chk.sv
module dio_bit_port_chk #(
    parameter int unsigned N_TERM = 16,
    localparam int unsigned IDX_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  sel,
    input logic              set_en,
    input logic              clr_en,
    input logic              sense_en,
    input logic [N_TERM-1:0] pin_in,
    input logic [N_TERM-1:0] pin_out,
    input logic              sense_valid,
    input logic              sense_bit
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (&pin_out) && !sense_valid && !sense_bit);

    // R2
    set_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && !clr_en) |=> pin_out[$past(sel)]);

    // R3 R4
    clr_addr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !pin_out[$past(sel)]);

    // R5
    sense_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        sense_en |=> sense_valid && (sense_bit == ($past(pin_out[sel]) & $past(pin_in[sel]))));

    // R6
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !sense_en |=> !sense_valid && !sense_bit);

    // R7
    hold_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(pin_out));
endmodule

bind dio_bit_port dio_bit_port_chk #(.N_TERM(N_TERM)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel         (sel),
    .set_en      (set_en),
    .clr_en      (clr_en),
    .sense_en    (sense_en),
    .pin_in      (pin_in),
    .pin_out     (pin_out),
    .sense_valid (sense_valid),
    .sense_bit   (sense_bit)
);

// File: tb/sim_dio_bit_port.sv
module sim_dio_bit_port;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    sel = '0;
    logic          set_en = 1'b0, clr_en = 1'b0, sense_en = 1'b0;
    logic [NT-1:0] pin_in = '1;
    logic [NT-1:0] pin_out;
    logic          sense_valid, sense_bit;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    logic [NT-1:0] m_latch;
    logic          m_valid, m_bit;

    always #(CLK_PERIOD/2) clk = ~clk;

    dio_bit_port u0 (
        .clk(clk), .rst(rst), .sel(sel), .set_en(set_en), .clr_en(clr_en),
        .sense_en(sense_en), .pin_in(pin_in), .pin_out(pin_out),
        .sense_valid(sense_valid), .sense_bit(sense_bit)
    );

    // Behavioural reference: sense reads the old latch (R8), clear beats set (R4).
    always @(posedge clk) begin
        if (rst) begin
            m_latch = '1;
            m_valid = 1'b0;
            m_bit   = 1'b0;
        end else begin
            m_valid = sense_en;
            m_bit   = sense_en & m_latch[sel] & pin_in[sel];
            if (clr_en)      m_latch[sel] = 1'b0;
            else if (set_en) m_latch[sel] = 1'b1;
        end
    end

    task automatic compare();
        n_cmp++;
        if (pin_out !== m_latch) begin
            n_bad++;
            $display("FAIL %s pin_out actual=%h expected=%h", tag, pin_out, m_latch);
        end
        n_cmp++;
        if (sense_valid !== m_valid || sense_bit !== m_bit) begin
            n_bad++;
            $display("FAIL %s sense actual=%b/%b expected=%b/%b", tag,
                     sense_valid, sense_bit, m_valid, m_bit);
        end
    endtask

    task automatic step(input logic [3:0] s, input logic st, input logic cl,
                        input logic se, input logic [NT-1:0] pi);
        sel = s; set_en = st; clr_en = cl; sense_en = se; pin_in = pi;
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        compare();
        rst = 1'b0;

        // R2 R3: random single writes
        tag = "R2 R3 write";
        for (int i = 0; i < 200; i++)
            step(4'($urandom), 1'($urandom), 1'($urandom), 1'b0, NT'($urandom));

        // R4: set and clear together
        tag = "R4";
        for (int i = 0; i < 16; i++) step(4'(i), 1'b1, 1'b1, 1'b0, '1);
        for (int i = 0; i < 16; i += 2) step(4'(i), 1'b1, 1'b0, 1'b0, '1);

        // R5: all four latch/external combinations on every index
        tag = "R5 wired sense";
        for (int i = 0; i < 16; i++) begin
            step(4'(i), 1'b0, 1'b0, 1'b1, '1);
            step(4'(i), 1'b0, 1'b0, 1'b1, ~(NT'(1) << i));
        end
        for (int i = 0; i < 16; i++) step(4'(i), 1'b1, 1'b0, 1'b0, '1);
        for (int i = 0; i < 16; i++) begin
            step(4'(i), 1'b0, 1'b0, 1'b1, NT'(1) << i);
            step(4'(i), 1'b0, 1'b0, 1'b1, ~(NT'(1) << i));
        end

        // R8: sense and write in the same cycle
        tag = "R8";
        step(4'd5, 1'b0, 1'b1, 1'b1, '1);
        step(4'd5, 1'b1, 1'b0, 1'b1, '1);
        step(4'd5, 1'b0, 1'b0, 1'b1, '1);

        // R6 R7: idle with changing index and external level
        tag = "R6 R7 idle";
        for (int i = 0; i < 100; i++)
            step(4'($urandom), 1'b0, 1'b0, 1'($urandom), NT'($urandom));

        // mixed traffic
        tag = "R2 R3 R5 mixed";
        for (int i = 0; i < 500; i++)
            step(4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), NT'($urandom));

        // R1: reset mid-run
        tag = "R1 rerun";
        step(4'd0, 1'b0, 1'b1, 1'b1, '0);
        rst = 1'b1;
        step(4'd1, 1'b0, 1'b1, 1'b1, '0);
        rst = 1'b0;
        step(4'd1, 1'b0, 1'b0, 1'b0, '1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule